// File: doc/BRIEF.md
# VGA Raster Timing and CPU Clock Generator

This block produces the complete raster timing for a 640x480 display from a single pixel clock of nominally 25.175 MHz. Two chained position counters track the current pixel and line. From them the block decodes two blanking flags and two active-low sync pulses. It also keeps a running index of visible pixels that can address video RAM directly, and raises a one-cycle interrupt strobe at the start of vertical blanking. Pixel colour passes through the block and is forced to black whenever either blanking flag is set.

From the same pixel clock the block derives two quadrature processor clocks, E and Q, each at one sixteenth of the pixel rate. Q leads E by a quarter period. Because both come from one counter, every processor cycle stays locked to the raster. All timing figures are parameters, so a small raster can be built for test.

Top module: `vga_timing_gen`

## Requirements
- R1: `hpos_o` steps by one on every clock from 0 to H_TOT-1 and then wraps to 0. `vpos_o` steps by one each time `hpos_o` wraps, runs from 0 to V_TOT-1 and then wraps to 0. By default a line is 800 clocks (640 visible, 16 front porch, 96 sync, 48 back porch) and a frame is 525 lines (480 visible, 10 front porch, 2 sync, 33 back porch).
- R2: Let k be the number of clock edges since reset, taken modulo CPU_DIV (default 16), and let phase = k/(CPU_DIV/4). `cpu_e_o` is high for phases 2 and 3. `cpu_q_o` is high for phases 1 and 2. Both outputs are registered and both are low in reset.
- R3: `hblank_o` is high exactly when `hpos_o` >= H_VIS. `hsync_no` is low exactly when H_VIS+H_FP <= `hpos_o` < H_VIS+H_FP+H_SYNC.
- R4: `vblank_o` is high exactly when `vpos_o` >= V_VIS. `vsync_no` is low exactly when V_VIS+V_FP <= `vpos_o` < V_VIS+V_FP+V_SYNC.
- R5: During every visible pixel, `pix_idx_o` equals `vpos_o`*H_VIS + `hpos_o`. During blanking it holds its value, except in the cycle after the last clock of a frame, when it is 0.
- R6: `rgb_o` equals `rgb_i` during visible pixels. It is all zeros whenever `hblank_o` or `vblank_o` is high.
- R7: `vblank_irq_o` is high for exactly one clock, the clock in which `vpos_o` = V_VIS and `hpos_o` = 0, which is the rising edge of vertical blanking. It is low at all other times.
- R8: When `rst_ni` goes low, the block resets at once, without waiting for a clock edge. Both position counters and `pix_idx_o` become 0, and both processor clocks go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rgb_i | input | RGB_W | Pixel colour from video RAM |
| hpos_o | output | $clog2(H_TOT) | Horizontal position |
| vpos_o | output | $clog2(V_TOT) | Vertical position |
| hblank_o | output | 1 | Horizontal blanking flag |
| hsync_no | output | 1 | Horizontal sync, active low |
| vblank_o | output | 1 | Vertical blanking flag |
| vsync_no | output | 1 | Vertical sync, active low |
| pix_idx_o | output | $clog2(H_VIS*V_VIS+1) | Linear index of visible pixels |
| rgb_o | output | RGB_W | Colour output, black during blanking |
| vblank_irq_o | output | 1 | One-cycle strobe at the start of vertical blanking |
| cpu_q_o | output | 1 | Quadrature processor clock Q |
| cpu_e_o | output | 1 | Processor clock E |

## Verification
The bench targets the wrap points: the last pixel of a line, the last line of a frame, and the frame boundary. At the frame boundary a pixel index that fails to clear would keep counting past H_VIS*V_VIS. An off-by-one in any porch or sync bound moves a sync edge by one clock, and the cycle-by-cycle compare catches that. The interrupt is checked in every cycle, so a level-type strobe or one that fires on the falling edge of blanking is caught. A reset applied in the middle of a frame checks that both processor clocks restart from phase 0, and that a Q or E swapped in phase is caught.

// File: rtl/vga_tg_pkg.sv
package vga_tg_pkg;
  typedef struct packed {
    logic blank;
    logic sync_n;
  } axis_flags_t;
endpackage

// File: rtl/vga_tg_axis.sv
module vga_tg_axis
  import vga_tg_pkg::*;
#(
  parameter int VIS  = 640,
  parameter int FP   = 16,
  parameter int SYNC = 96,
  parameter int BP   = 48,
  localparam int TOT = VIS + FP + SYNC + BP,
  localparam int CW  = $clog2(TOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output axis_flags_t   flags_o
);
  localparam logic [CW-1:0] LAST_V  = CW'(TOT - 1);
  localparam logic [CW-1:0] SYNC_LO = CW'(VIS + FP);
  localparam logic [CW-1:0] SYNC_HI = CW'(VIS + FP + SYNC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= (cnt_q == LAST_V) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o          = cnt_q;
  assign last_o         = (cnt_q == LAST_V);
  assign flags_o.blank  = (cnt_q >= CW'(VIS));
  assign flags_o.sync_n = !((cnt_q >= SYNC_LO) && (cnt_q < SYNC_HI));
endmodule

// File: rtl/vga_tg_cpu_clk.sv
module vga_tg_cpu_clk #(
  parameter int CPU_DIV = 16,
  localparam int DW = $clog2(CPU_DIV)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic q_o,
  output logic e_o
);
  logic [DW-1:0] div_q;
  logic [DW-1:0] div_nxt;
  logic          q_q, e_q;

  assign div_nxt = div_q + 1'b1;

  // top two bits give the quarter phase; Q = phase 1,2 ; E = phase 2,3
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      q_q   <= 1'b0;
      e_q   <= 1'b0;
    end else begin
      div_q <= div_nxt;
      e_q   <= div_nxt[DW-1];
      q_q   <= div_nxt[DW-1] ^ div_nxt[DW-2];
    end
  end

  assign q_o = q_q;
  assign e_o = e_q;
endmodule

// File: rtl/vga_tg_pix_idx.sv
module vga_tg_pix_idx #(
  parameter int NPIX = 640 * 480,
  localparam int PW = $clog2(NPIX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          visible_i,
  input  logic          frame_end_i,
  output logic [PW-1:0] idx_o
);
  logic [PW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          idx_q <= '0;
    else if (frame_end_i) idx_q <= '0;
    else if (visible_i)   idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/vga_timing_gen.sv
module vga_timing_gen
  import vga_tg_pkg::*;
#(
  parameter int H_VIS   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter int RGB_W   = 3,
  parameter int CPU_DIV = 16,
  localparam int H_TOT  = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT  = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW     = $clog2(H_TOT),
  localparam int VW     = $clog2(V_TOT),
  localparam int PW     = $clog2(H_VIS * V_VIS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RGB_W-1:0] rgb_i,
  output logic [HW-1:0]    hpos_o,
  output logic [VW-1:0]    vpos_o,
  output logic             hblank_o,
  output logic             hsync_no,
  output logic             vblank_o,
  output logic             vsync_no,
  output logic [PW-1:0]    pix_idx_o,
  output logic [RGB_W-1:0] rgb_o,
  output logic             vblank_irq_o,
  output logic             cpu_q_o,
  output logic             cpu_e_o
);
  axis_flags_t hf, vf;
  logic        h_last, v_last;
  logic        blank;
  logic        vblank_q;

  vga_tg_axis #(.VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) u_h (
    .clk_i, .rst_ni, .step_i(1'b1),
    .cnt_o(hpos_o), .last_o(h_last), .flags_o(hf)
  );

  vga_tg_axis #(.VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) u_v (
    .clk_i, .rst_ni, .step_i(h_last),
    .cnt_o(vpos_o), .last_o(v_last), .flags_o(vf)
  );

  assign hblank_o = hf.blank;
  assign hsync_no = hf.sync_n;
  assign vblank_o = vf.blank;
  assign vsync_no = vf.sync_n;
  assign blank    = hf.blank | vf.blank;

  vga_tg_pix_idx #(.NPIX(H_VIS * V_VIS)) u_pix (
    .clk_i, .rst_ni, .visible_i(!blank),
    .frame_end_i(h_last & v_last), .idx_o(pix_idx_o)
  );

  assign rgb_o = blank ? '0 : rgb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vblank_q <= 1'b0;
    else         vblank_q <= vf.blank;
  end

  assign vblank_irq_o = vf.blank & ~vblank_q;

  vga_tg_cpu_clk #(.CPU_DIV(CPU_DIV)) u_cpu (
    .clk_i, .rst_ni, .q_o(cpu_q_o), .e_o(cpu_e_o)
  );
endmodule

// File: rtl/vga_tg_checks.sv
module vga_tg_checks #(
  parameter int H_VIS = 640,
  parameter int H_TOT = 800,
  parameter int V_VIS = 480,
  parameter int V_TOT = 525,
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int PW = 19,
  parameter int RGB_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [HW-1:0]    hpos_o,
  input logic [VW-1:0]    vpos_o,
  input logic             hblank_o,
  input logic             hsync_no,
  input logic             vblank_o,
  input logic             vsync_no,
  input logic [PW-1:0]    pix_idx_o,
  input logic [RGB_W-1:0] rgb_o,
  input logic             vblank_irq_o,
  input logic             cpu_q_o,
  input logic             cpu_e_o
);
  p_hwrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpos_o == HW'(H_TOT - 1)) |=> (hpos_o == '0));
  p_vhold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hpos_o != HW'(H_TOT - 1)) |=> $stable(vpos_o));
  p_qe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_e_o) |-> cpu_q_o);
  p_hsync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_no |-> hblank_o);
  p_vsync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_no |-> vblank_o);
  p_pix_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hblank_o && !vblank_o) |=> (pix_idx_o == PW'($past(pix_idx_o) + 1'b1)));
  p_pix_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hblank_o || vblank_o) &&
     !(hpos_o == HW'(H_TOT - 1) && vpos_o == VW'(V_TOT - 1))) |=> $stable(pix_idx_o));
  p_black_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hblank_o || vblank_o) |-> (rgb_o == '0));
  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_irq_o |=> !vblank_irq_o);
  p_irq_pos_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_irq_o |-> (vpos_o == VW'(V_VIS) && hpos_o == '0));
endmodule

bind vga_timing_gen vga_tg_checks #(
  .H_VIS(H_VIS), .H_TOT(H_TOT), .V_VIS(V_VIS), .V_TOT(V_TOT),
  .HW(HW), .VW(VW), .PW(PW), .RGB_W(RGB_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hpos_o(hpos_o), .vpos_o(vpos_o),
  .hblank_o(hblank_o), .hsync_no(hsync_no), .vblank_o(vblank_o),
  .vsync_no(vsync_no), .pix_idx_o(pix_idx_o), .rgb_o(rgb_o),
  .vblank_irq_o(vblank_irq_o), .cpu_q_o(cpu_q_o), .cpu_e_o(cpu_e_o)
);

// File: tb/vga_timing_gen_test.sv
module vga_timing_gen_test;
  localparam int HV = 8, HF = 2, HS = 3, HB = 2;
  localparam int VV = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int DIV = 16;
  localparam int HW = $clog2(HT);
  localparam int VW = $clog2(VT);
  localparam int PW = $clog2(HV * VV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] rgb_i = '0;
  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  logic hblank, hsync_n, vblank, vsync_n, irq, cq, ce;
  logic [PW-1:0] pix;
  logic [2:0] rgb_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  int h, v, n, p;

  always #2 clk = ~clk;

  vga_timing_gen #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .RGB_W(3), .CPU_DIV(DIV)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .rgb_i(rgb_i),
    .hpos_o(hpos), .vpos_o(vpos), .hblank_o(hblank), .hsync_no(hsync_n),
    .vblank_o(vblank), .vsync_no(vsync_n), .pix_idx_o(pix), .rgb_o(rgb_o),
    .vblank_irq_o(irq), .cpu_q_o(cq), .cpu_e_o(ce)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at h=%0d v=%0d n=%0d: actual %0d expected %0d", req, h, v, n, act, exp);
    end
  endtask

  task automatic model_reset();
    h = 0; v = 0; n = 0; p = 0;
  endtask

  task automatic model_step();
    bit vis_old, end_old;
    vis_old = (h < HV) && (v < VV);
    end_old = (h == HT - 1) && (v == VT - 1);
    if (end_old) p = 0;
    else if (vis_old) p++;
    if (h == HT - 1) begin
      h = 0;
      v = (v == VT - 1) ? 0 : v + 1;
    end else h++;
    n++;
  endtask

  task automatic compare_all();
    int ph;
    bit hb, vb;
    hb = (h >= HV);
    vb = (v >= VV);
    ph = (n % DIV) / (DIV / 4);
    chk("R1 hpos", int'(hpos), h);
    chk("R1 vpos", int'(vpos), v);
    chk("R2 cpu_e", int'(ce), int'(ph >= 2));
    chk("R2 cpu_q", int'(cq), int'(ph == 1 || ph == 2));
    chk("R3 hblank", int'(hblank), int'(hb));
    chk("R3 hsync", int'(hsync_n), int'(!(h >= HV + HF && h < HV + HF + HS)));
    chk("R4 vblank", int'(vblank), int'(vb));
    chk("R4 vsync", int'(vsync_n), int'(!(v >= VV + VF && v < VV + VF + VS)));
    chk("R5 pix_idx", int'(pix), p);
    if (!hb && !vb) chk("R5 pix_idx formula", int'(pix), v * HV + h);
    chk("R6 rgb", int'(rgb_o), (hb || vb) ? 0 : int'(rgb_i));
    chk("R7 irq", int'(irq), int'(v == VV && h == 0));
  endtask

  task automatic run(input int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk);
      model_step();
      #1 rgb_i = 3'($urandom_range(7, 0));
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic reset_checks();
    chk("R8 hpos reset", int'(hpos), 0);
    chk("R8 vpos reset", int'(vpos), 0);
    chk("R8 pix reset", int'(pix), 0);
    chk("R8 cpu_q reset", int'(cq), 0);
    chk("R8 cpu_e reset", int'(ce), 0);
  endtask

  initial begin
    model_reset();
    rgb_i = 3'b101;
    repeat (3) @(negedge clk);
    reset_checks();
    compare_all();
    rst_n = 1'b1;
    run(3 * HT * VT + 37);
    // asynchronous reset mid-frame, away from a clock edge
    #1 rst_n = 1'b0;
    #0.5;
    model_reset();
    reset_checks();
    @(negedge clk);
    reset_checks();
    rst_n = 1'b1;
    run(2 * HT * VT + 11);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule